// File: doc/BRIEF.md
# Modem Control and Status Register Block

This block holds the modem control and modem status registers of a 16550-compatible serial port. No modem pins come in. The modem status is derived from the control bits. With the internal loopback bit clear, carrier detect and data-set-ready read as asserted, so a driver opening the port never blocks. With loopback set, the four control outputs are reflected back into the four status inputs. This lets a probing driver confirm that the port exists.

Change flags are computed only when the control register is written. They stay set until the status register is read. A modem-status interrupt request is raised while any change flag is set and the matching enable bit is set. In loopback, a byte written to the transmit holding register goes to a receive-path output instead of the transmit output, and the overrun flag is set.

The register bus has separate read and write offsets, so a read and a write can land in the same clock cycle.

Top module: `modem_ctl_regs`

## Requirements
- R1: After reset, the control register (offset 4) reads 0x00, the status register (offset 6) reads 0xA0, the line status register (offset 5) reads 0x00, and `irq_msr` is low.
- R2: A write to offset 4 stores bits 4:0 only (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 LOOP). Bits 7:5 always read as zero.
- R3: With LOOP clear, status bits 7:4 read 1010: DCD (bit 7) and DSR (bit 5) are 1, RI (bit 6) and CTS (bit 4) are 0, whatever the other control bits are.
- R4: With LOOP set, CTS follows RTS, DSR follows DTR, RI follows OUT1 and DCD follows OUT2.
- R5: On a control write, DCTS (bit 0), DDSR (bit 1) and DDCD (bit 3) are set when CTS, DSR or DCD change, in either direction.
- R6: TERI (bit 2) is set only when RI falls from 1 to 0. A rising RI sets no flag.
- R7: Change flags are sticky. A control write ORs new detections into them and never clears them.
- R8: A read of offset 6 returns the current value, and all four change flags are clear from the next cycle. A change detected by a control write in the same cycle survives the clear.
- R9: `irq_msr` is high exactly while any change flag is set and enable bit 3 of the interrupt-enable register (offset 1, bits 3:0 stored) is set.
- R10: With LOOP clear, a write to offset 0 drives `tx_valid` high with `tx_data` equal to the byte for one cycle after the write. `lb_valid` stays low.
- R11: With LOOP set, a write to offset 0 drives `lb_valid` high with `lb_data` equal to the byte for one cycle after the write. `tx_valid` stays low, and the overrun flag (offset 5, bit 1) is set.
- R12: A read of offset 5 returns the overrun flag at bit 1 and clears it. An overrun set by a write in the same cycle survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, with side effects taken at the clock edge |
| rd_addr | input | 3 | Read register offset |
| rd_data | output | 8 | Read data, valid in the strobe cycle, zero otherwise |
| irq_msr | output | 1 | Modem-status interrupt request |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| lb_valid | output | 1 | Loopback receive byte strobe |
| lb_data | output | 8 | Loopback receive byte |

## Verification
Two pairs of functions can collide in one cycle. A status read that clears the change flags can coincide with a control write that detects a new change. A line-status read that clears overrun can coincide with a loopback transmit write that sets it. The bench provokes both by asserting both strobes together. It judges each collision in two steps. The read data must show the old value. The following read must show the newly detected flag still set while the older flags are gone.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 5;

    // register offsets decoded by software
    localparam logic [ADDR_W-1:0] OFS_THR = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IER = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_MCR = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LSR = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MSR = 3'd6;

    // control bit positions
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_OUT1 = 2;
    localparam int C_OUT2 = 3;
    localparam int C_LOOP = 4;

    // status nibble index (bit+4 in MSR); change flag uses same index
    localparam int S_CTS = 0;
    localparam int S_DSR = 1;
    localparam int S_RI  = 2;
    localparam int S_DCD = 3;

    localparam logic [3:0] IDLE_STATUS = 4'b1010; // DCD and DSR high
    localparam int IER_MS_BIT = 3;
    localparam int LSR_OE_BIT = 1;

    typedef struct packed {
        logic [CTRL_W-1:0] mcr;
        logic [3:0]        ier;
        logic [3:0]        delta;
        logic              oe;
        logic              tx_vld;
        logic [DATA_W-1:0] tx_byte;
        logic              lb_vld;
        logic [DATA_W-1:0] lb_byte;
    } regs_t;
endpackage

// File: rtl/msr_status_map.sv
module msr_status_map
    import mcr_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output logic [3:0]        status
);
    always_comb begin
        if (ctrl[C_LOOP]) begin
            status[S_CTS] = ctrl[C_RTS];
            status[S_DSR] = ctrl[C_DTR];
            status[S_RI]  = ctrl[C_OUT1];
            status[S_DCD] = ctrl[C_OUT2];
        end else begin
            status = IDLE_STATUS;
        end
    end
endmodule

// File: rtl/msr_delta_detect.sv
module msr_delta_detect
    import mcr_pkg::*;
(
    input  logic [3:0] old_status,
    input  logic [3:0] new_status,
    output logic [3:0] change
);
    for (genvar i = 0; i < 4; i++) begin : g_bit
        if (i == S_RI) begin : g_fall
            assign change[i] = old_status[i] & ~new_status[i];
        end else begin : g_both
            assign change[i] = old_status[i] ^ new_status[i];
        end
    end
endmodule

// File: rtl/modem_ctl_regs.sv
module modem_ctl_regs
    import mcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_msr,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              lb_valid,
    output logic [DATA_W-1:0] lb_data
);
    regs_t st_d, st_q;

    logic [3:0] cur_status, new_status, detect;
    logic       wr_mcr, wr_thr, wr_ier, rd_msr, rd_lsr;
    logic [DATA_W-1:0] rd_mux;

    // aliases for the bound checker
    logic [CTRL_W-1:0] cur_mcr;
    logic [3:0]        cur_ier;
    logic [3:0]        cur_delta;
    assign cur_mcr   = st_q.mcr;
    assign cur_ier   = st_q.ier;
    assign cur_delta = st_q.delta;

    msr_status_map u_map_cur (.ctrl(st_q.mcr), .status(cur_status));
    msr_status_map u_map_new (.ctrl(wr_data[CTRL_W-1:0]), .status(new_status));
    msr_delta_detect u_det (.old_status(cur_status), .new_status(new_status), .change(detect));

    assign wr_mcr = wr_en && (wr_addr == OFS_MCR);
    assign wr_thr = wr_en && (wr_addr == OFS_THR);
    assign wr_ier = wr_en && (wr_addr == OFS_IER);
    assign rd_msr = rd_en && (rd_addr == OFS_MSR);
    assign rd_lsr = rd_en && (rd_addr == OFS_LSR);

    always_comb begin
        st_d        = st_q;
        st_d.tx_vld = 1'b0;
        st_d.lb_vld = 1'b0;

        // change flags: read clears old ones, fresh detections survive
        st_d.delta = (rd_msr ? 4'd0 : st_q.delta) | (wr_mcr ? detect : 4'd0);
        st_d.oe    = rd_lsr ? 1'b0 : st_q.oe;

        if (wr_mcr) begin
            st_d.mcr = wr_data[CTRL_W-1:0];
        end
        if (wr_ier) begin
            st_d.ier = wr_data[3:0];
        end
        if (wr_thr) begin
            if (st_q.mcr[C_LOOP]) begin
                st_d.lb_vld  = 1'b1;
                st_d.lb_byte = wr_data;
                st_d.oe      = 1'b1;
            end else begin
                st_d.tx_vld  = 1'b1;
                st_d.tx_byte = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (rd_addr)
            OFS_IER: rd_mux = {4'd0, st_q.ier};
            OFS_MCR: rd_mux = {{(DATA_W-CTRL_W){1'b0}}, st_q.mcr};
            OFS_LSR: rd_mux[LSR_OE_BIT] = st_q.oe;
            OFS_MSR: rd_mux = {cur_status, st_q.delta};
            default: rd_mux = '0;
        endcase
    end

    assign rd_data  = rd_en ? rd_mux : '0;
    assign irq_msr  = st_q.ier[IER_MS_BIT] && (st_q.delta != 4'd0);
    assign tx_valid = st_q.tx_vld;
    assign tx_data  = st_q.tx_byte;
    assign lb_valid = st_q.lb_vld;
    assign lb_data  = st_q.lb_byte;
endmodule

module modem_ctl_chk
    import mcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_msr,
    input logic              tx_valid,
    input logic              lb_valid,
    input logic [CTRL_W-1:0] cur_mcr,
    input logic [3:0]        cur_ier,
    input logic [3:0]        cur_delta
);
    AST_MCR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFS_MCR) |-> (rd_data[7:5] == 3'd0)); // R2

    AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFS_MSR && !cur_mcr[C_LOOP]) |-> (rd_data[7:4] == 4'hA)); // R3

    AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_MCR && !(rd_en && rd_addr == OFS_MSR))
        |=> ((cur_delta & $past(cur_delta)) == $past(cur_delta))); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFS_MSR && !(wr_en && wr_addr == OFS_MCR))
        |=> (cur_delta == 4'd0)); // R8

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msr |-> cur_ier[IER_MS_BIT]); // R9

    AST_LOOP_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_THR && cur_mcr[C_LOOP]) |=> (lb_valid && !tx_valid)); // R11
endmodule

bind modem_ctl_regs modem_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_msr(irq_msr),
    .tx_valid(tx_valid), .lb_valid(lb_valid), .cur_mcr(cur_mcr),
    .cur_ier(cur_ier), .cur_delta(cur_delta)
);

// File: tb/sim_modem_ctl_regs.sv
module sim_modem_ctl_regs;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_msr, tx_valid, lb_valid;
    logic [7:0] tx_data, lb_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_msr(irq_msr),
        .tx_valid(tx_valid), .tx_data(tx_data), .lb_valid(lb_valid), .lb_data(lb_data)
    );

    typedef struct packed {
        logic       w;
        logic [2:0] wa;
        logic [7:0] wd;
        logic       r;
        logic [2:0] ra;
        logic [7:0] erd;
        logic       eirq;
    } vec_t;

    localparam int NV = 24;
    // rd_data and irq are judged inside the row's cycle, before its edge
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 8'h00, 1'b0}, // 0 R1 MCR reset
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 8'hA0, 1'b0}, // 1 R1 MSR reset
        '{1'b1, 3'd4, 8'hFF, 1'b1, 3'd5, 8'h00, 1'b0}, // 2 R1 LSR reset
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 8'h1F, 1'b0}, // 3 R2 mask
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 8'hF1, 1'b0}, // 4 R4 R5 CTS rise
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 8'hF0, 1'b0}, // 5 R8 cleared
        '{1'b1, 3'd1, 8'h08, 1'b0, 3'd0, 8'h00, 1'b0}, // 6 enable
        '{1'b1, 3'd4, 8'h10, 1'b1, 3'd1, 8'h08, 1'b0}, // 7 all fall
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 8'h0F, 1'b1}, // 8 R5 R6 R9
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 8'h10, 1'b0}, // 9 R9 irq drops
        '{1'b1, 3'd4, 8'h14, 1'b0, 3'd0, 8'h00, 1'b0}, // 10 RI rise
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 8'h40, 1'b0}, // 11 R6 no TERI
        '{1'b1, 3'd4, 8'h10, 1'b0, 3'd0, 8'h00, 1'b0}, // 12 RI fall
        '{1'b1, 3'd4, 8'h11, 1'b0, 3'd0, 8'h00, 1'b1}, // 13 DSR rise
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 8'h26, 1'b1}, // 14 R7 sticky
        '{1'b1, 3'd4, 8'h10, 1'b0, 3'd0, 8'h00, 1'b0}, // 15 DSR fall
        '{1'b1, 3'd4, 8'h18, 1'b1, 3'd6, 8'h02, 1'b1}, // 16 R8 collide
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 8'h88, 1'b1}, // 17 R8 survivor
        '{1'b1, 3'd4, 8'h19, 1'b0, 3'd0, 8'h00, 1'b0}, // 18 DSR rise
        '{1'b1, 3'd1, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1}, // 19 disable
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 8'hA2, 1'b0}, // 20 R9 gated
        '{1'b1, 3'd4, 8'h03, 1'b0, 3'd0, 8'h00, 1'b0}, // 21 loop off
        '{1'b1, 3'd4, 8'h0C, 1'b1, 3'd6, 8'hA0, 1'b0}, // 22 R3
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 8'hA0, 1'b0}  // 23 R3
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [2:0] wa, input logic [7:0] wd,
                         input logic r, input logic [2:0] ra);
        @(negedge clk);
        wr_en = w; wr_addr = wa; wr_data = wd;
        rd_en = r; rd_addr = ra;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 8'h00, 1'b0, 3'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].w, VEC[i].wa, VEC[i].wd, VEC[i].r, VEC[i].ra);
            if (VEC[i].r) check($sformatf("R1-table row %0d rd", i), rd_data, VEC[i].erd);
            check($sformatf("R9 row %0d irq", i), {7'd0, irq_msr}, {7'd0, VEC[i].eirq});
        end

        // R10: transmit path with loop clear (MCR is 0x0C here)
        drive(1'b1, 3'd0, 8'h5A, 1'b0, 3'd0);
        idle();
        check("R10 tx_valid", {7'd0, tx_valid}, 8'h01);
        check("R10 tx_data", tx_data, 8'h5A);
        check("R10 lb_valid", {7'd0, lb_valid}, 8'h00);
        idle();
        check("R10 tx_valid one cycle", {7'd0, tx_valid}, 8'h00);

        // R11: loopback steering
        drive(1'b1, 3'd4, 8'h10, 1'b0, 3'd0);
        drive(1'b1, 3'd0, 8'hC3, 1'b0, 3'd0);
        idle();
        check("R11 lb_valid", {7'd0, lb_valid}, 8'h01);
        check("R11 lb_data", lb_data, 8'hC3);
        check("R11 tx_valid", {7'd0, tx_valid}, 8'h00);
        drive(1'b0, 3'd0, 8'h00, 1'b1, 3'd5);
        check("R11 R12 overrun read", rd_data, 8'h02);
        drive(1'b0, 3'd0, 8'h00, 1'b1, 3'd5);
        check("R12 overrun cleared", rd_data, 8'h00);

        // R12: overrun set in the clearing cycle survives
        drive(1'b1, 3'd0, 8'h11, 1'b1, 3'd5);
        check("R12 collide read", rd_data, 8'h00);
        drive(1'b0, 3'd0, 8'h00, 1'b1, 3'd5);
        check("R12 survivor", rd_data, 8'h02);

        // R1: reset mid-run with flags pending
        drive(1'b1, 3'd1, 8'h08, 1'b0, 3'd0);
        drive(1'b1, 3'd4, 8'h1F, 1'b0, 3'd0);
        idle();
        check("R1 irq before reset", {7'd0, irq_msr}, 8'h01);
        rst_n = 1'b0;
        #1;
        drive(1'b0, 3'd0, 8'h00, 1'b1, 3'd6);
        rst_n = 1'b1;
        #1;
        check("R1 MSR after reset", rd_data, 8'hA0);
        check("R1 irq after reset", {7'd0, irq_msr}, 8'h00);
        drive(1'b0, 3'd0, 8'h00, 1'b1, 3'd4);
        check("R1 MCR after reset", rd_data, 8'h00);
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule